// File: doc/BRIEF.md
# Hash Engine Data-Size Accounting Register

This block keeps the running balance of message bits that a message-digest core still has to hash. It also decides, cycle by cycle, whether the core may pull its next 64-bit word from its private input FIFO. Software or a descriptor fetcher programs the balance through a register write port. Each accepted write is added, as a signed quantity, to the balance already held. Writes may therefore be split across several transfers. A negative contribution can hold data back until a later write lifts the total above zero. Every word the core consumes removes 64 bits from the balance.

Each data-size write is screened before it is added. A value with a sub-byte remainder is refused. While the continue mode is active, a value that is not a whole number of 512-bit blocks is also refused. A refused write leaves the balance alone and raises a sticky data-size error. A second register holds the HMAC key length in bytes. Lengths above 64 are refused and raise a sticky key-size error. Both registers can be read back through a selectable read port.

Top module: `digest_size_acct`

## Requirements
- R1: After reset the balance and the key length read as zero, both error flags are low and `procEn` is low.
- R2: A data-size write (`wrEn`=1, `wrSel`=0) that passes the checks adds `wrData`, taken as 21-bit two's complement, to the balance one cycle later. Successive writes accumulate.
- R3: A `wordTaken` pulse lowers the balance by 64. When a write and a pulse arrive in the same cycle, both apply in that cycle.
- R4: `procEn` is high exactly when the balance is greater than zero and `fifoNotEmpty` is high.
- R5: A balance of zero or below is legal. It keeps `procEn` low until later writes bring it above zero.
- R6: A data-size write whose bits [2:0] are not all zero sets `sizeErr` and leaves the balance unchanged by that write.
- R7: While `contMode` is high, a data-size write whose bits [8:0] are not all zero sets `sizeErr` and is not added. While `contMode` is low, a value that is a multiple of 8 but not of 512 is accepted.
- R8: A key-size write (`wrEn`=1, `wrSel`=1) of a value up to 64, taken as unsigned, is stored. A larger value sets `keyErr` and leaves the stored length unchanged.
- R9: Both error flags stay set until `errClear` is high. A new error in the same cycle as `errClear` leaves the flag set.
- R10: The balance saturates at +1048575 and at -1048576 and never wraps.
- R11: `rdData` shows the balance in two's complement when `rdSel`=0, and the zero-extended key length when `rdSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 data size, 1 key size |
| wrData | input | 21 | Write value |
| contMode | input | 1 | Continue mode; enforces 512-bit block alignment |
| rdSel | input | 1 | Read source: 0 balance, 1 key length |
| rdData | output | 21 | Readback value |
| fifoNotEmpty | input | 1 | Input FIFO holds at least one word |
| wordTaken | input | 1 | Core consumed one 64-bit word |
| errClear | input | 1 | Clears both error flags |
| procEn | output | 1 | Core may take the next word |
| sizeErr | output | 1 | Sticky data-size error |
| keyErr | output | 1 | Sticky key-size error |

## Verification
The hardest states to reach from the ports are the two saturation rails. Small random writes seldom reach them, and word consumption always pulls the balance back. Directed sequences therefore issue repeated near-limit writes of +1048568 and -1048576 with consumption idle, so the bench can confirm clamping at each rail. Random traffic then runs from those extremes, mixing aligned and misaligned values under both continue settings. Coincident writes, consumes and error clears are part of that mix.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic addData;    // accept data-size write into balance
    logic consume;    // subtract one word
    logic loadKey;    // store key length
    logic setSizeErr; // misaligned data-size write
    logic setKeyErr;  // oversize key write
    logic clearErr;   // clear both flags
  } ctrl_s;
endpackage

// File: rtl/dsa_ctrl.sv
module dsa_ctrl
  import dsa_pkg::*;
#(
  parameter int DATA_W     = 21,
  parameter int OFFSET_LSB = 3,
  parameter int BLOCK_LSB  = 9,
  parameter int KEY_MAX    = 64
) (
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              contMode,
  input  logic              fifoNotEmpty,
  input  logic              wordTaken,
  input  logic              errClear,
  input  logic              cntPositive,
  output ctrl_s             strb,
  output logic              procEn
);
  logic dataWr, keyWr, offsetOk, blockOk, aligned, keyTooBig;

  assign dataWr    = wrEn && !wrSel;
  assign keyWr     = wrEn && wrSel;
  assign offsetOk  = (wrData[OFFSET_LSB-1:0] == '0);
  assign blockOk   = (wrData[BLOCK_LSB-1:0] == '0);
  assign aligned   = offsetOk && (!contMode || blockOk);
  assign keyTooBig = (wrData > DATA_W'(KEY_MAX));

  always_comb begin
    strb            = '0;
    strb.addData    = dataWr && aligned;
    strb.setSizeErr = dataWr && !aligned;
    strb.loadKey    = keyWr && !keyTooBig;
    strb.setKeyErr  = keyWr && keyTooBig;
    strb.consume    = wordTaken;
    strb.clearErr   = errClear;
  end

  assign procEn = cntPositive && fifoNotEmpty;
endmodule

// File: rtl/dsa_datapath.sv
module dsa_datapath
  import dsa_pkg::*;
#(
  parameter int DATA_W    = 21,
  parameter int WORD_BITS = 64,
  parameter int KEY_MAX   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              cntPositive,
  output logic              sizeErr,
  output logic              keyErr
);
  localparam int KEY_W = $clog2(KEY_MAX + 1);
  localparam int EXT_W = DATA_W + 2;
  localparam logic signed [EXT_W-1:0] CNT_MAX = EXT_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] CNT_MIN = -EXT_W'(1 << (DATA_W - 1));

  logic signed [DATA_W-1:0] count;
  logic [KEY_W-1:0]         keyLen;
  logic signed [EXT_W-1:0]  addend, takeAmt, sum;
  logic signed [DATA_W-1:0] countNext;

  always_comb begin
    addend  = strb.addData ? EXT_W'($signed(wrData)) : '0;
    takeAmt = strb.consume ? EXT_W'(WORD_BITS) : '0;
    sum     = EXT_W'(count) + addend - takeAmt;
    if (sum > CNT_MAX)      countNext = CNT_MAX[DATA_W-1:0];
    else if (sum < CNT_MIN) countNext = CNT_MIN[DATA_W-1:0];
    else                    countNext = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      keyLen  <= '0;
      sizeErr <= 1'b0;
      keyErr  <= 1'b0;
    end else begin
      count   <= countNext;
      if (strb.loadKey) keyLen <= wrData[KEY_W-1:0];
      sizeErr <= strb.setSizeErr | (sizeErr & ~strb.clearErr);
      keyErr  <= strb.setKeyErr  | (keyErr  & ~strb.clearErr);
    end
  end

  assign cntPositive = (count > 0);
  assign rdData = rdSel ? {{(DATA_W-KEY_W){1'b0}}, keyLen} : count;

  // R6
  size_err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setSizeErr |=> sizeErr);
  // R9
  size_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeErr && !strb.clearErr) |=> sizeErr);
  // R8
  key_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setKeyErr |=> (keyErr && $stable(keyLen)));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.addData && !strb.consume) |=> $stable(count));
  // R10
  sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (EXT_W'(count) == CNT_MAX && strb.addData && !wrData[DATA_W-1] && !strb.consume)
      |=> (EXT_W'(count) == CNT_MAX));
  // R8
  key_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyLen <= KEY_W'(KEY_MAX));
endmodule

// File: rtl/digest_size_acct.sv
module digest_size_acct
  import dsa_pkg::*;
#(
  parameter int DATA_W     = 21,
  parameter int WORD_BITS  = 64,
  parameter int OFFSET_LSB = 3,
  parameter int BLOCK_LSB  = 9,
  parameter int KEY_MAX    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              contMode,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              fifoNotEmpty,
  input  logic              wordTaken,
  input  logic              errClear,
  output logic              procEn,
  output logic              sizeErr,
  output logic              keyErr
);
  ctrl_s strb;
  logic  cntPositive;

  dsa_ctrl #(
    .DATA_W(DATA_W), .OFFSET_LSB(OFFSET_LSB), .BLOCK_LSB(BLOCK_LSB), .KEY_MAX(KEY_MAX)
  ) ctrl_i (
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .contMode(contMode),
    .fifoNotEmpty(fifoNotEmpty), .wordTaken(wordTaken), .errClear(errClear),
    .cntPositive(cntPositive), .strb(strb), .procEn(procEn)
  );

  dsa_datapath #(
    .DATA_W(DATA_W), .WORD_BITS(WORD_BITS), .KEY_MAX(KEY_MAX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .cntPositive(cntPositive), .sizeErr(sizeErr), .keyErr(keyErr)
  );

  // R4
  proc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    procEn |-> (fifoNotEmpty && !rdData[DATA_W-1]) || rdSel);
endmodule

// File: tb/digest_size_acct_tb_top.sv
module digest_size_acct_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0, contMode = 1'b0, rdSel = 1'b0;
  logic [20:0] wrData = '0;
  logic        fifoNotEmpty = 1'b0, wordTaken = 1'b0, errClear = 1'b0;
  logic [20:0] rdData;
  logic        procEn, sizeErr, keyErr;

  int checks = 0, errors = 0;
  int mCount = 0, mKey = 0;
  bit mSizeErr = 0, mKeyErr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  digest_size_acct dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .contMode(contMode), .rdSel(rdSel), .rdData(rdData),
    .fifoNotEmpty(fifoNotEmpty), .wordTaken(wordTaken), .errClear(errClear),
    .procEn(procEn), .sizeErr(sizeErr), .keyErr(keyErr)
  );

  function automatic int satCount(int v);
    if (v > 1048575) return 1048575;
    if (v < -1048576) return -1048576;
    return v;
  endfunction

  function automatic bit isAligned(logic [20:0] d, bit cm);
    return (d[2:0] == 3'b0) && (!cm || d[8:0] == 9'b0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    rdSel = 1'b0; #1;
    chk({req, " balance"}, int'($signed(rdData)), mCount);
    rdSel = 1'b1; #1;
    chk({req, " key"}, int'(rdData), mKey);
    chk({req, " sizeErr"}, int'(sizeErr), int'(mSizeErr));
    chk({req, " keyErr"}, int'(keyErr), int'(mKeyErr));
    chk({req, " procEn R4"}, int'(procEn), int'(mCount > 0 && fifoNotEmpty));
  endtask

  // drives one cycle at the negedge, updates the model, checks at the next negedge
  task automatic cycle(bit we, bit sel, logic [20:0] d, bit cm, bit take,
                       bit clr, bit fifo, string req);
    bit dataWr = we && !sel;
    bit keyWr  = we && sel;
    bit ok     = isAligned(d, cm);
    bit kBad   = (int'(d) > 64);
    wrEn = we; wrSel = sel; wrData = d; contMode = cm;
    wordTaken = take; errClear = clr; fifoNotEmpty = fifo;
    @(posedge clk);
    mCount   = satCount(mCount + ((dataWr && ok) ? int'($signed(d)) : 0) - (take ? 64 : 0));
    if (keyWr && !kBad) mKey = int'(d);
    mSizeErr = (dataWr && !ok) || (mSizeErr && !clr);
    mKeyErr  = (keyWr && kBad) || (mKeyErr && !clr);
    @(negedge clk);
    wrEn = 1'b0; wordTaken = 1'b0; errClear = 1'b0;
    checkAll(req);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");

    // R2 accumulation, R4/R5 gating
    cycle(1, 0, 21'd512, 0, 0, 0, 1, "R2 first write");
    cycle(1, 0, 21'd128, 0, 0, 0, 1, "R2 second write");
    cycle(1, 0, -21'sd1024, 0, 0, 0, 1, "R5 negative");
    cycle(0, 0, 0, 0, 0, 0, 1, "R5 held back");
    cycle(1, 0, 21'd448, 0, 0, 0, 0, "R4 fifo empty");
    // R3 consume and simultaneous write
    cycle(1, 0, 21'd256, 0, 1, 0, 1, "R3 write plus consume");
    cycle(0, 0, 0, 0, 1, 0, 1, "R3 consume");
    // R6 offset error
    cycle(1, 0, 21'd13, 0, 0, 0, 1, "R6 bit offset");
    cycle(0, 0, 0, 0, 0, 1, 1, "R9 clear");
    // R7 continue alignment
    cycle(1, 0, 21'd72, 1, 0, 0, 1, "R7 cont misaligned");
    cycle(1, 0, 21'd72, 0, 0, 1, 1, "R7 no cont accepted, R9 clear");
    cycle(1, 0, 21'd1024, 1, 0, 0, 1, "R7 cont aligned");
    // R9 set wins over clear
    cycle(1, 0, 21'd4, 0, 0, 1, 1, "R9 set beats clear");
    cycle(0, 0, 0, 0, 0, 0, 1, "R9 sticky");
    // R8 key
    cycle(1, 1, 21'd64, 0, 0, 1, 1, "R8 key at limit");
    cycle(1, 1, 21'd65, 0, 0, 0, 1, "R8 key too big");
    cycle(1, 1, 21'h1FFFFF, 0, 0, 0, 1, "R8 key huge");
    cycle(1, 1, 21'd20, 0, 0, 1, 1, "R8 R11 key readback");
    // R10 saturation
    repeat (3) cycle(1, 0, 21'd1048568, 0, 0, 0, 1, "R10 high rail");
    repeat (4) cycle(1, 0, 21'h100000, 1, 0, 0, 1, "R10 low rail");
    cycle(1, 0, 21'h100000, 0, 1, 0, 1, "R10 low rail with consume");

    // R11 random mix
    for (int i = 0; i < 600; i++) begin
      int kind = $urandom_range(0, 9);
      logic [20:0] d;
      if (kind < 5)      d = 21'($urandom_range(0, 4095)) << 9;
      else if (kind < 7) d = 21'($urandom_range(0, 131071)) << 3;
      else if (kind < 8) d = 21'($urandom_range(0, 2097151));
      else               d = 21'($urandom_range(0, 100));
      cycle($urandom_range(0, 2) != 0, kind >= 8, d, $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 3) != 0, "R11 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule